// File: doc/BRIEF.md
# Execute-in-Place Read Front End for a Multi-I/O Serial Flash

This block sits behind the pins of a multi-I/O serial flash and handles the command side of fast reads. It can run in either of two states. In the normal state, every transaction opens with an eight-clock opcode on DQ0. In execute-in-place (XIP) state, a transaction opens directly with the address on two or four I/O lines, with no opcode. In both states a read then runs a fixed number of dummy clocks and streams bytes from the memory read port until chip select is released.

During the first dummy clock, DQ0 carries a confirmation bit. A 0 keeps the device in XIP, or puts it there, for the next transaction. A 1 sends the next transaction back to opcode decoding. After power-on or a reset pulse, a nonvolatile configuration input decides whether the device starts in XIP, and a second input sets its bus width. The host may idle the clock low or high between transactions. Inputs are sampled on rising edges and outputs change on falling edges.

Top module: `xip_flash_front`

## Requirements
- R1: While reset is held, the XIP state is loaded from `nv_xip_en` and the XIP bus width from `nv_quad` (1 = four lines, 0 = two lines). With `nv_xip_en` = 1, the first transaction has no opcode and starts with the address. With `nv_xip_en` = 0, it needs an opcode.
- R2: The confirmation bit is the DQ0 value sampled on the first rising edge of the dummy phase. A value of 0 keeps XIP, so the next transaction again starts with the address.
- R3: A confirmation bit of 1 ends XIP. The next transaction is decoded as an opcode, and an address-only transaction sent then produces no output (`dq_oe` stays 0000).
- R4: During the confirmation clock, DQ3..DQ1 in a quad read, and DQ1 in a dual read, have no effect on the XIP decision.
- R5: The address is ADDR_W bits, most significant first. A quad read takes ADDR_W/4 clocks on DQ3..DQ0. A dual read takes ADDR_W/2 clocks on DQ1..DQ0.
- R6: DUMMY_CYC clocks follow the address. Data then changes on falling edges, most significant bits first. A quad read sends 4 bits per clock with `dq_oe` = 1111. A dual read sends 2 bits per clock on DQ1..DQ0 with `dq_oe` = 0011. The first data bits are valid at the first rising edge after the dummy phase.
- R7: The read address, presented on `mem_addr`, steps by one after every byte and wraps from all-ones to zero.
- R8: In the normal state, the opcode is 8 bits on DQ0, most significant bit first. 0xEB selects a quad read and 0xBB selects a dual read. Any other value produces no output until chip select rises.
- R9: Raising `cs_n` forces `dq_oe` to 0000 at once and restarts the phase sequence. A transaction cut off before its confirmation clock leaves the XIP state unchanged.
- R10: A low pulse on `rst_n` restores the power-on XIP state and width from the configuration inputs, and `dq_oe` is 0000 while reset is held.
- R11: An opcode read also samples the confirmation bit. A 0 enters XIP with that read's bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled on rising edge, outputs updated on falling edge |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cs_n | input | 1 | Active-low chip select framing each transaction |
| nv_xip_en | input | 1 | Nonvolatile setting: start in XIP after reset |
| nv_quad | input | 1 | Nonvolatile setting: XIP width after reset (1 quad, 0 dual) |
| dq_in | input | 4 | Values seen on DQ3..DQ0 |
| dq_out | output | 4 | Values driven onto DQ3..DQ0 |
| dq_oe | output | 4 | Per-line output enable for DQ3..DQ0 |
| mem_addr | output | ADDR_W | Byte address presented to the memory read port |
| mem_rdata | input | 8 | Byte returned combinationally for `mem_addr` |

## Verification
The bench builds the block with ADDR_W = 32, so the address wrap at 0xFFFFFFFF is reached within three bytes of a read. It sets DUMMY_CYC = 3, so the dummy count differs from the default and the confirmation clock, which is the first dummy clock, is not also the last. With these values, each transaction costs a few dozen clocks, which leaves room to enter and leave XIP by each route, in both widths.

// File: rtl/xip_pkg.sv
// Shared types for the XIP read front end.
// Assumes: one phase register in the sequencer, read by the output stage.
package xip_pkg;
    typedef enum logic [2:0] {
        PH_OPC   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_DATA  = 3'd3,
        PH_HALT  = 3'd4
    } phase_t;

    localparam logic [7:0] OPC_QUAD_RD = 8'hEB;
    localparam logic [7:0] OPC_DUAL_RD = 8'hBB;
endpackage

// File: rtl/xip_state.sv
// Holds the XIP flag and the XIP bus width.
// Loads both from the configuration inputs while reset is low, and
// updates them only when the sequencer reports a sampled confirmation bit.
module xip_state (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_xip_en,
    input  logic nv_quad,
    input  logic conf_strobe,
    input  logic conf_bit,
    input  logic cur_quad,
    output logic xip_active,
    output logic xip_quad
);
    // Update the XIP flag and width on reset or on a confirmation sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xip_active <= nv_xip_en;
            xip_quad   <= nv_quad;
        end else if (conf_strobe) begin
            xip_active <= ~conf_bit;
            xip_quad   <= cur_quad;
        end
    end
endmodule

// File: rtl/xip_seq.sv
// Phase sequencer: opcode, address, dummy, data.
// Samples DQ on rising edges. Restarts whenever chip select is high.
// Assumes at least one rising edge with chip select high between transactions.
module xip_seq
    import xip_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DUMMY_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [3:0]        dq_in,
    input  logic              nv_xip_en,
    input  logic              nv_quad,
    input  logic              xip_active,
    input  logic              xip_quad,
    output phase_t            phase,
    output logic              quad,
    output logic [1:0]        slot,
    output logic [ADDR_W-1:0] addr,
    output logic              conf_strobe,
    output logic              conf_bit
);
    localparam int QA_CLKS = ADDR_W / 4;
    localparam int DA_CLKS = ADDR_W / 2;
    localparam int MAXC_A  = (DA_CLKS > 8) ? DA_CLKS : 8;
    localparam int MAXC    = (MAXC_A > DUMMY_CYC) ? MAXC_A : DUMMY_CYC;
    localparam int CNT_W   = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       opc;
    logic [7:0]       opc_next;
    logic [CNT_W-1:0] addr_last;

    assign opc_next    = {opc[6:0], dq_in[0]};
    assign addr_last   = quad ? CNT_W'(QA_CLKS - 1) : CNT_W'(DA_CLKS - 1);
    assign conf_strobe = !cs_n && (phase == PH_DUMMY) && (cnt == '0);
    assign conf_bit    = dq_in[0];
    assign slot        = cnt[1:0];

    // Advance the phase and counters on each selected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= nv_xip_en ? PH_ADDR : PH_OPC;
            quad  <= nv_quad;
            cnt   <= '0;
            opc   <= '0;
            addr  <= '0;
        end else if (cs_n) begin
            phase <= xip_active ? PH_ADDR : PH_OPC;
            quad  <= xip_quad;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_OPC: begin
                    opc <= opc_next;
                    if (cnt == CNT_W'(7)) begin
                        cnt <= '0;
                        if (opc_next == OPC_QUAD_RD) begin
                            phase <= PH_ADDR;
                            quad  <= 1'b1;
                        end else if (opc_next == OPC_DUAL_RD) begin
                            phase <= PH_ADDR;
                            quad  <= 1'b0;
                        end else begin
                            phase <= PH_HALT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    addr <= quad ? {addr[ADDR_W-5:0], dq_in}
                                 : {addr[ADDR_W-3:0], dq_in[1:0]};
                    if (cnt == addr_last) begin
                        cnt   <= '0;
                        phase <= PH_DUMMY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (cnt == CNT_W'(DUMMY_CYC - 1)) begin
                        cnt   <= '0;
                        phase <= PH_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt == (quad ? CNT_W'(1) : CNT_W'(3))) begin
                        cnt  <= '0;
                        addr <= addr + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_HALT;
            endcase
        end
    end

    // R9: a deselected edge always restarts at the opcode or address phase.
    a_r9_cs_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_OPC || phase == PH_ADDR));

    // R2: the XIP flag follows the inverted DQ0 value of the confirmation clock.
    a_r2_conf_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && phase == PH_DUMMY && cnt == '0) |=> (xip_active == !$past(dq_in[0])));

    // R8: an unknown opcode parks the sequencer.
    a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && phase == PH_OPC && cnt == CNT_W'(7)
         && opc_next != OPC_QUAD_RD && opc_next != OPC_DUAL_RD) |=> (phase == PH_HALT));

    // R5: the address phase lasts exactly its clock count, then the dummy phase begins.
    a_r5_addr_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && phase == PH_ADDR && cnt == addr_last) |=> (phase == PH_DUMMY && cnt == '0));
endmodule

// File: rtl/xip_dout.sv
// Output stage: registers the data bits and the enables on falling edges.
// It chooses the bits of the current byte by the slot index from the sequencer.
// Assumes mem_rdata is valid combinationally for the current address.
module xip_dout
    import xip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  phase_t     phase,
    input  logic       quad,
    input  logic [1:0] slot,
    input  logic [7:0] rdata,
    output logic [3:0] out_q,
    output logic [3:0] oe_q
);
    // Launch the next data slot on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n || cs_n || phase != PH_DATA) begin
            out_q <= 4'h0;
            oe_q  <= 4'h0;
        end else if (quad) begin
            out_q <= slot[0] ? rdata[3:0] : rdata[7:4];
            oe_q  <= 4'hF;
        end else begin
            case (slot)
                2'd0:    out_q <= {2'b00, rdata[7:6]};
                2'd1:    out_q <= {2'b00, rdata[5:4]};
                2'd2:    out_q <= {2'b00, rdata[3:2]};
                default: out_q <= {2'b00, rdata[1:0]};
            endcase
            oe_q <= 4'h3;
        end
    end

    // R6: a quad data phase drives all four lines.
    a_r6_quad_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && phase == PH_DATA && quad) |-> (oe_q == 4'hF));

    // R6: a dual data phase drives only DQ1..DQ0.
    a_r6_dual_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && phase == PH_DATA && !quad) |-> (oe_q == 4'h3));
endmodule

// File: rtl/xip_flash_front.sv
// Top of the XIP read front end: sequencer, XIP state and output stage.
// Output enables are gated by chip select so that deselection tri-states at once.
module xip_flash_front
    import xip_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DUMMY_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              nv_xip_en,
    input  logic              nv_quad,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    phase_t     phase;
    logic       quad;
    logic [1:0] slot;
    logic       conf_strobe;
    logic       conf_bit;
    logic       xip_active;
    logic       xip_quad;
    logic [3:0] out_q;
    logic [3:0] oe_q;

    xip_state u_state (
        .clk(clk), .rst_n(rst_n), .nv_xip_en(nv_xip_en), .nv_quad(nv_quad),
        .conf_strobe(conf_strobe), .conf_bit(conf_bit), .cur_quad(quad),
        .xip_active(xip_active), .xip_quad(xip_quad)
    );

    xip_seq #(.ADDR_W(ADDR_W), .DUMMY_CYC(DUMMY_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in),
        .nv_xip_en(nv_xip_en), .nv_quad(nv_quad),
        .xip_active(xip_active), .xip_quad(xip_quad),
        .phase(phase), .quad(quad), .slot(slot), .addr(mem_addr),
        .conf_strobe(conf_strobe), .conf_bit(conf_bit)
    );

    xip_dout u_dout (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .phase(phase), .quad(quad),
        .slot(slot), .rdata(mem_rdata), .out_q(out_q), .oe_q(oe_q)
    );

    assign dq_oe  = oe_q & {4{~cs_n}};
    assign dq_out = out_q;
endmodule

// File: tb/sim_xip_flash_front.sv
module sim_xip_flash_front;
    localparam int AW = 32;
    localparam int DC = 3;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, nv_xip_en, nv_quad;
    logic [3:0]  dq_in, dq_out, dq_oe;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;
    int checks = 0;
    int errors = 0;
    logic [3:0] cap_o, cap_oe;

    always #2 clk = ~clk;

    function automatic logic [7:0] model(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
    endfunction
    assign mem_rdata = model(mem_addr);

    xip_flash_front #(.ADDR_W(AW), .DUMMY_CYC(DC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .nv_xip_en(nv_xip_en),
        .nv_quad(nv_quad), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_io(input logic [3:0] v);
        dq_in = v;
        @(negedge clk);
        #1;
        cap_o  = dq_out;
        cap_oe = dq_oe;
    endtask

    // One transaction. abort_nib > 0 raises cs_n after that many data slots.
    task automatic xfer(input bit use_opc, input logic [7:0] opc, input bit quad,
                        input logic [31:0] a, input logic [3:0] conf, input int nbytes,
                        input bit expect_data, input int abort_nib, input string req);
        int slots;
        int total;
        logic [7:0] b;
        slots = quad ? 2 : 4;
        total = nbytes * slots;
        cs_n = 1'b0;
        if (use_opc)
            for (int i = 7; i >= 0; i--) clk_io({3'b000, opc[i]});
        if (quad) for (int i = 7; i >= 0; i--) clk_io(a[i*4 +: 4]);
        else      for (int i = 15; i >= 0; i--) clk_io({2'b00, a[i*2 +: 2]});
        clk_io(conf);
        for (int i = 1; i < DC; i++) clk_io(4'h0);
        b = 8'h00;
        for (int k = 0; k < total; k++) begin
            if (k > 0) clk_io(4'h0);
            if (!expect_data) begin
                chk({req, " no output"}, {28'h0, cap_oe}, 32'h0);
            end else begin
                chk({req, " oe width"}, {28'h0, cap_oe}, quad ? 32'hF : 32'h3);
                b = quad ? {b[3:0], cap_o} : {b[5:0], cap_o[1:0]};
                if ((k % slots) == slots - 1)
                    chk({req, " data byte"}, {24'h0, b}, {24'h0, model(a + 32'(k / slots))});
            end
            if (abort_nib > 0 && k + 1 == abort_nib) begin
                cs_n = 1'b1;
                #0.5;
                chk("R9 deselect tri-state", {28'h0, dq_oe}, 32'h0);
                break;
            end
        end
        cs_n = 1'b1;
        clk_io(4'h0);
        clk_io(4'h0);
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        clk_io(4'h0);
        chk("R10 oe low in reset", {28'h0, dq_oe}, 32'h0);
        clk_io(4'h0);
        rst_n = 1'b1;
        clk_io(4'h0);
    endtask

    // Table rows: {address, confirmation nibble, byte count}, all quad XIP.
    localparam logic [39:0] TBL [4] = '{
        {32'h0000_1000, 4'b0000, 4'd2},
        {32'h1234_5678, 4'b1110, 4'd3},
        {32'hFFFF_FFFE, 4'b0000, 4'd3},
        {32'h00AB_CDEF, 4'b0001, 4'd2}
    };

    initial begin
        cs_n = 1'b1; rst_n = 1'b0; nv_xip_en = 1'b1; nv_quad = 1'b1; dq_in = 4'h0;
        @(negedge clk); #1;
        clk_io(4'h0); clk_io(4'h0);
        chk("R10 reset state oe", {28'h0, dq_oe}, 32'h0);
        rst_n = 1'b1;
        clk_io(4'h0);
        // R1 power-on XIP, R2 stay, R4 DQ3..1 ignored, R7 wrap, R3 exit
        for (int r = 0; r < 4; r++)
            xfer(1'b0, 8'h00, 1'b1, TBL[r][39:8], TBL[r][7:4], int'(TBL[r][3:0]),
                 1'b1, 0, "R1 R2 R4 R5 R6 R7 quad xip row");
        xfer(1'b0, 8'h00, 1'b1, 32'h0, 4'h0, 2, 1'b0, 0, "R3 address-only after exit");
        xfer(1'b1, 8'h3C, 1'b1, 32'h40, 4'h0, 2, 1'b0, 0, "R8 unknown opcode");
        xfer(1'b1, 8'hEB, 1'b1, 32'h40, 4'h0, 2, 1'b1, 0, "R8 R11 quad opcode read");
        xfer(1'b0, 8'h00, 1'b1, 32'h80, 4'h1, 2, 1'b1, 0, "R11 xip entered");
        xfer(1'b1, 8'hBB, 1'b0, 32'h0102_0304, 4'h0, 2, 1'b1, 0, "R5 R8 dual opcode read");
        xfer(1'b0, 8'h00, 1'b0, 32'h55, 4'b0010, 2, 1'b1, 0, "R4 dual DQ1 ignored");
        // R9 abort inside the address phase keeps XIP
        cs_n = 1'b0;
        for (int i = 0; i < 4; i++) clk_io(4'hF);
        cs_n = 1'b1;
        clk_io(4'h0); clk_io(4'h0);
        xfer(1'b0, 8'h00, 1'b0, 32'h99, 4'h1, 2, 1'b1, 0, "R9 xip kept after abort");
        xfer(1'b1, 8'hEB, 1'b1, 32'h300, 4'h0, 2, 1'b1, 1, "R9 abort in data");
        xfer(1'b0, 8'h00, 1'b1, 32'h10, 4'h1, 1, 1'b1, 0, "R9 R2 xip after sampled conf");
        xfer(1'b0, 8'h00, 1'b1, 32'h0, 4'h0, 1, 1'b0, 0, "R3 standard again");
        // R10 reset restores XIP with dual width from the configuration
        nv_quad = 1'b0;
        pulse_reset();
        xfer(1'b0, 8'h00, 1'b0, 32'h2000, 4'h0, 2, 1'b1, 0, "R10 R1 dual xip after reset");
        // R1 configuration disabled: opcode needed after reset
        nv_xip_en = 1'b0;
        pulse_reset();
        xfer(1'b0, 8'h00, 1'b1, 32'h0, 4'h0, 1, 1'b0, 0, "R1 xip disabled");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule